// File: doc/BRIEF.md
# Split-Aware Shared Bus Arbiter

This block decides which of several bus masters drives a pipelined system bus. Master 0 is the processor and owns every other arbitration slot; the remaining masters share the slots in between in rotating order. Slots the processor leaves unused go to the other masters, and shared slots nobody else wants go back to the processor. Nothing is wasted while anyone is asking.

The arbiter also handles split transfers. When the slave answers the current master with a SPLIT response, that master is parked, or masked. It stays parked until the slave raises the master's bit in the split-release vector. The slave the master was addressing is then treated as busy. Any other request tagged for that slave is held back until the release arrives. A freshly released master is boosted so that it gets back onto the bus at the next decision. Each request carries a target-slave tag, and the arbiter decodes no addresses of its own.

The grant is registered, is always one-hot, and comes with the binary index of the granted master.

Top module: `split_bus_arbiter`

## Requirements
- R1: While reset is held low, and after it is released, until the first decision, the grant is master 0 (`grant_idx` = 0, `grant` = 1).
- R2: A decision happens only on a clock edge where `hready` is 1. With `hready` at 0 the grant holds unchanged.
- R3: Decisions alternate between processor slots and shared slots, and the first decision after reset is a processor slot. In a processor slot, an eligible master 0 is granted.
- R4: In a shared slot with no boosted master, the eligible masters 1..N-1 are searched in circular order. The search starts just after the master most recently picked by that rotating search.
- R5: In a processor slot where master 0 is not eligible, the slot goes to a boosted or rotating pick. In a shared slot where no boosted master and no other master is eligible, an eligible master 0 is granted.
- R6: When no master is eligible, the grant goes to master 0.
- R7: A SPLIT response (`resp` = 2'b11) on an edge with `hready` at 1 masks the currently granted master. A masked master is never granted, and that holds at that same decision too.
- R8: A bit of `split_rel` unmasks the matching master only if that master is masked. A release bit for an unmasked master has no effect.
- R9: A released master is boosted. A boosted eligible master wins any decision except a processor slot with master 0 eligible. Among several boosted masters the lowest index wins and the rest keep their boost. A boost clears when its master is granted.
- R10: A request whose tag (bits `req_slv[i*SW +: SW]`) names a slave that a masked master was addressing when it was split is not eligible until that master is released.
- R11: `grant` is always one-hot and equal to 1 shifted left by `grant_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_MST | Request line per master, bit 0 is the processor |
| req_slv | input | N_MST*SW | Target-slave tag per master, SW bits each |
| hready | input | 1 | Current transfer completes or bus idle; enables a decision |
| resp | input | 2 | Slave response: 00 okay, 01 error, 10 retry, 11 split |
| split_rel | input | N_MST | Per-master split release from slaves |
| grant | output | N_MST | One-hot bus grant |
| grant_idx | output | IDX_W | Index of the granted master |

## Verification
The hardest state to reach is two masters released on the same edge while a third master is blocked behind a still-split slave. Getting there needs two masters split against different slaves, one per transfer. A third master's request must be tagged for one of those slaves, and both releases must arrive together. The bench gets there by granting a chosen master on purpose: it requests only from that master until it is granted, then answers with SPLIT. The directed steps are followed by an exhaustive sweep of every request and tag pattern of a four-master, two-slave configuration, and then by a long pseudo-random run of splits and releases. A cycle-level reference model in the bench predicts every grant.

// File: rtl/sba_pkg.sv
// Shared types for the split-aware bus arbiter.
package sba_pkg;
    // Slave response code on the bus.
    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b01,
        RESP_RETRY = 2'b10,
        RESP_SPLIT = 2'b11
    } sba_resp_e;

    // Kind of the next arbitration slot.
    typedef enum logic {
        SLOT_PROC   = 1'b0,
        SLOT_SHARED = 1'b1
    } sba_slot_e;
endpackage

// File: rtl/sba_first_pick.sv
// Circular first-set finder.
// Searches vec starting at the position just after 'after' and wrapping round.
// It reports whether any bit is set and the index of the first one found.
// Assumes N_MST >= 2. Purely combinational.
module sba_first_pick #(
    parameter int N_MST = 16,
    localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] vec,
    input  logic [IW-1:0]    after,
    output logic             found,
    output logic [IW-1:0]    idx
);
    int pos;

    // Walk N_MST positions after 'after' and keep the first set bit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = 0;
        for (int k = 1; k <= N_MST; k++) begin
            pos = int'(after) + k;
            if (pos >= N_MST) pos = pos - N_MST;
            if (!found && vec[pos[IW-1:0]]) begin
                found = 1'b1;
                idx   = pos[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/sba_split_track.sv
// Split bookkeeping for the arbiter.
// Holds, per master, the masked flag, the slave it was split against and the
// boost flag. From these it derives which requests are blocked.
// Assumes split_idx is the master granted for the transfer that got the SPLIT.
// Assumes a release for a master that is not masked must be ignored.
module sba_split_track #(
    parameter int N_MST = 16,
    parameter int N_SLV = 4,
    localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1,
    localparam int SW = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                split_now,
    input  logic [IW-1:0]       split_idx,
    input  logic [SW-1:0]       split_slv,
    input  logic [N_MST-1:0]    rel,
    input  logic [N_MST-1:0]    clr_boost,
    input  logic [N_MST*SW-1:0] req_slv,
    output logic [N_MST-1:0]    mask_eff,
    output logic [N_MST-1:0]    blocked,
    output logic [N_MST-1:0]    boost_q
);
    logic [N_MST-1:0] mask_q;
    logic [N_MST-1:0] split_hot;
    logic [SW-1:0]    mslv_q   [N_MST];
    logic [SW-1:0]    mslv_eff [N_MST];
    logic [N_SLV-1:0] busy;

    assign split_hot = split_now ? (N_MST'(1) << split_idx) : '0;
    // A master split on this edge is already excluded from this decision.
    assign mask_eff  = mask_q | split_hot;

    for (genvar g = 0; g < N_MST; g++) begin : g_mst
        // Slave that this master is parked against, including a split on this edge.
        assign mslv_eff[g] = split_hot[g] ? split_slv : mslv_q[g];

        // Request blocked if its tagged slave has a split outstanding.
        assign blocked[g] = busy[req_slv[g*SW +: SW]];

        // Remember the slave a master was split against.
        always_ff @(posedge clk) begin
            if (!rst_n)            mslv_q[g] <= '0;
            else if (split_hot[g]) mslv_q[g] <= split_slv;
        end
    end

    // Mark each slave that some masked master is waiting on.
    always_comb begin
        busy = '0;
        for (int s = 0; s < N_SLV; s++) begin
            for (int i = 0; i < N_MST; i++) begin
                if (mask_eff[i] && (mslv_eff[i] == SW'(s))) busy[s] = 1'b1;
            end
        end
    end

    // Update masks and boosts: only masked masters can be released and boosted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            boost_q <= '0;
        end else begin
            mask_q  <= (mask_q & ~rel) | split_hot;
            boost_q <= (boost_q & ~clr_boost) | (rel & mask_q);
        end
    end
endmodule

// File: rtl/split_bus_arbiter.sv
// Split-aware bus arbiter, top level.
// Slots alternate between processor (master 0) and shared. Shared slots rotate
// over masters 1..N-1, and any slot left unused goes to whoever is eligible.
// Released masters are boosted ahead of the rotation. Requests to a slave with
// a split outstanding are held off.
// Assumes hready high means the bus is idle or a transfer ends this cycle.
// Assumes resp is only meaningful together with hready.
module split_bus_arbiter
    import sba_pkg::*;
#(
    parameter int N_MST = 16,
    parameter int N_SLV = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1,
    localparam int SW    = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_MST-1:0]    req,
    input  logic [N_MST*SW-1:0] req_slv,
    input  logic                hready,
    input  logic [1:0]          resp,
    input  logic [N_MST-1:0]    split_rel,
    output logic [N_MST-1:0]    grant,
    output logic [IDX_W-1:0]    grant_idx
);
    logic [N_MST-1:0] mask_eff, blocked, boost_q, elig;
    logic [N_MST-1:0] boost_cand, rot_cand, clr_boost;
    logic [N_MST-1:0] grant_q;
    logic [IDX_W-1:0] grant_idx_q, rr_q, nxt_idx, bst_idx, rot_idx;
    logic [SW-1:0]    gslv_q;
    logic             split_now, bst_found, rot_found, rot_adv;
    sba_slot_e        slot_q;

    assign split_now = hready && (resp == RESP_SPLIT);

    sba_split_track #(.N_MST(N_MST), .N_SLV(N_SLV)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .split_now (split_now),
        .split_idx (grant_idx_q),
        .split_slv (gslv_q),
        .rel       (split_rel),
        .clr_boost (clr_boost),
        .req_slv   (req_slv),
        .mask_eff  (mask_eff),
        .blocked   (blocked),
        .boost_q   (boost_q)
    );

    assign elig       = req & ~mask_eff & ~blocked;
    assign boost_cand = elig & boost_q;
    assign rot_cand   = elig & ~N_MST'(1);

    // Lowest boosted index: search starting after the top index.
    sba_first_pick #(.N_MST(N_MST)) u_boost_pick (
        .vec   (boost_cand),
        .after (IDX_W'(N_MST - 1)),
        .found (bst_found),
        .idx   (bst_idx)
    );

    // Rotating pick among the non-processor masters.
    sba_first_pick #(.N_MST(N_MST)) u_rot_pick (
        .vec   (rot_cand),
        .after (rr_q),
        .found (rot_found),
        .idx   (rot_idx)
    );

    // Choose the next master: processor slot, boost, rotation, processor, default.
    always_comb begin
        rot_adv = 1'b0;
        if (slot_q == SLOT_PROC && elig[0]) begin
            nxt_idx = '0;
        end else if (bst_found) begin
            nxt_idx = bst_idx;
        end else if (rot_found) begin
            nxt_idx = rot_idx;
            rot_adv = 1'b1;
        end else begin
            nxt_idx = '0;
        end
    end

    assign clr_boost = hready ? (N_MST'(1) << nxt_idx) : '0;

    // Register the decision on every hready edge and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_idx_q <= '0;
            grant_q     <= N_MST'(1);
            gslv_q      <= '0;
            slot_q      <= SLOT_PROC;
            rr_q        <= IDX_W'(N_MST - 1);
        end else if (hready) begin
            grant_idx_q <= nxt_idx;
            grant_q     <= N_MST'(1) << nxt_idx;
            gslv_q      <= req_slv[nxt_idx*SW +: SW];
            slot_q      <= (slot_q == SLOT_PROC) ? SLOT_SHARED : SLOT_PROC;
            if (rot_adv) rr_q <= nxt_idx;
        end
    end

    assign grant     = grant_q;
    assign grant_idx = grant_idx_q;
endmodule

// File: rtl/sba_checker.sv
// Protocol checker for split_bus_arbiter, attached by bind.
// Checks grant shape, hold during transfers, the idle default and split masking.
module sba_checker #(
    parameter int N_MST = 16,
    parameter int IW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] req,
    input logic             hready,
    input logic [1:0]       resp,
    input logic [N_MST-1:0] grant,
    input logic [IW-1:0]    grant_idx
);
    AST_GRANT_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        grant == (N_MST'(1) << grant_idx)); // R11

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(grant) && $stable(grant_idx))); // R2

    AST_IDLE_TO_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && req == '0) |=> (grant_idx == '0)); // R6

    AST_SPLIT_NOT_REGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && resp == 2'b11 && grant_idx != '0) |=> (grant_idx != $past(grant_idx))); // R7
endmodule

bind split_bus_arbiter sba_checker #(.N_MST(N_MST), .IW(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .hready    (hready),
    .resp      (resp),
    .grant     (grant),
    .grant_idx (grant_idx)
);

// File: tb/tb_split_bus_arbiter.sv
`timescale 1ns/1ps
// Bench for split_bus_arbiter with four masters and two slaves.
// A reference model built from the requirements predicts every grant.
module tb_split_bus_arbiter;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] req_slv = '0;
    logic       hready = 1'b0;
    logic [1:0] resp = 2'b00;
    logic [3:0] split_rel = '0;
    logic [3:0] grant;
    logic [1:0] grant_idx;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    logic [3:0] m_mask, m_boost, m_mslv;
    logic [1:0] m_idx, m_rr;
    logic       m_gslv, m_shared;

    split_bus_arbiter #(.N_MST(N), .N_SLV(2)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_slv(req_slv), .hready(hready),
        .resp(resp), .split_rel(split_rel), .grant(grant), .grant_idx(grant_idx)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = '0; m_boost = '0; m_mslv = '0;
        m_idx = '0; m_rr = 2'd3; m_gslv = 1'b0; m_shared = 1'b0;
    endtask

    // Advance the model by one clock edge with the given inputs.
    task automatic model_edge(input logic [3:0] r, input logic [3:0] rs, input logic hr,
                              input logic [1:0] rsp, input logic [3:0] rl);
        logic [3:0] sh, me, elig, busy_m;
        logic [1:0] busy, nidx;
        logic       done;
        sh = (hr && rsp == 2'b11) ? (4'b0001 << m_idx) : 4'b0000;
        me = m_mask | sh;
        busy = '0;
        for (int i = 0; i < N; i++) begin
            if (me[i]) busy[sh[i] ? m_gslv : m_mslv[i]] = 1'b1;
        end
        busy_m = '0;
        for (int i = 0; i < N; i++) busy_m[i] = busy[rs[i]];
        elig = r & ~me & ~busy_m;
        nidx = m_idx;
        if (hr) begin
            done = 1'b0;
            if (!m_shared && elig[0]) begin nidx = 0; done = 1'b1; end
            for (int i = 0; i < N; i++) begin
                if (!done && elig[i] && m_boost[i]) begin nidx = 2'(i); done = 1'b1; end
            end
            for (int k = 1; k <= N; k++) begin
                int p;
                p = (int'(m_rr) + k) % N;
                if (!done && p != 0 && elig[p]) begin
                    nidx = 2'(p); done = 1'b1; m_rr = 2'(p);
                end
            end
            if (!done) nidx = 0;
        end
        m_boost = (m_boost & ~(hr ? (4'b0001 << nidx) : 4'b0000)) | (rl & m_mask);
        m_mask  = (m_mask & ~rl) | sh;
        for (int i = 0; i < N; i++) if (sh[i]) m_mslv[i] = m_gslv;
        if (hr) begin
            m_idx = nidx;
            m_gslv = rs[nidx];
            m_shared = ~m_shared;
        end
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic step(input logic [3:0] r, input logic [3:0] rs, input logic hr,
                        input logic [1:0] rsp, input logic [3:0] rl, input string tag);
        @(negedge clk);
        req = r; req_slv = rs; hready = hr; resp = rsp; split_rel = rl;
        model_edge(r, rs, hr, rsp, rl);
        @(posedge clk);
        #1;
        check({tag, " idx"}, {2'b00, grant_idx}, {2'b00, m_idx});
        check("R11 onehot", grant, 4'b0001 << grant_idx);
    endtask

    // Get master m granted (requesting only from it) with tag t, then split it.
    task automatic split_master(input int m, input logic [3:0] rs, input string tag);
        for (int k = 0; k < 4; k++) begin
            if (m_idx != 2'(m)) step(4'b0001 << m, rs, 1'b1, 2'b00, 4'b0000, tag);
        end
        step(4'b0001 << m, rs, 1'b1, 2'b11, 4'b0000, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset idx", {2'b00, grant_idx}, 4'b0000);
        check("R1 reset grant", grant, 4'b0001);
        @(negedge clk);
        rst_n = 1'b1;
        req = 4'b1111;
        @(posedge clk);
        #1;
        check("R1 hold idx", {2'b00, grant_idx}, 4'b0000);

        // R2: no decision without hready.
        repeat (3) step(4'b1110, 4'b0000, 1'b0, 2'b00, 4'b0000, "R2");
        // R3/R4: all request, slots alternate and rotation advances.
        repeat (8) step(4'b1111, 4'b0000, 1'b1, 2'b00, 4'b0000, "R3 R4");
        // R5: processor idle or alone.
        repeat (4) step(4'b0110, 4'b0000, 1'b1, 2'b00, 4'b0000, "R5 others");
        repeat (3) step(4'b0001, 4'b0000, 1'b1, 2'b00, 4'b0000, "R5 proc");
        // R6: nobody requesting.
        repeat (2) step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0000, "R6");

        // R7: split master 2 against slave 1, then it must not be granted.
        split_master(2, 4'b0100, "R7");
        repeat (4) step(4'b0100, 4'b0100, 1'b1, 2'b00, 4'b0000, "R7 masked");
        // R10: master 3 tagged for slave 1 is blocked; master 1 on slave 0 is not.
        repeat (4) step(4'b1000, 4'b1100, 1'b1, 2'b00, 4'b0000, "R10 blocked");
        repeat (2) step(4'b1010, 4'b1100, 1'b1, 2'b00, 4'b0000, "R10 other");
        // R8: release of unmasked master 1 is ignored (no boost over rotation).
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0010, "R8 ignored");
        repeat (4) step(4'b1010, 4'b0000, 1'b1, 2'b00, 4'b0000, "R8 after");
        // R9: release master 2, it wins the next shared-capable decision.
        step(4'b0000, 4'b0100, 1'b1, 2'b00, 4'b0100, "R8 release");
        repeat (3) step(4'b1111, 4'b0100, 1'b1, 2'b00, 4'b0000, "R9 boost");

        // R9: two masters released together; lower index first, other keeps boost.
        split_master(1, 4'b0000, "R9 setup1");
        split_master(3, 4'b1000, "R9 setup3");
        repeat (2) step(4'b1110, 4'b1000, 1'b1, 2'b00, 4'b0000, "R10 two slaves");
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b1010, "R9 dual release");
        repeat (5) step(4'b1111, 4'b0000, 1'b1, 2'b00, 4'b0000, "R9 order");

        // Exhaustive sweep of request and tag patterns.
        for (int r = 0; r < 16; r++) begin
            for (int s = 0; s < 16; s++) begin
                step(4'(r), 4'(s), 1'b1, 2'b00, 4'b0000, "R4 R5 sweep");
            end
        end

        // Pseudo-random run with splits, releases and stalls.
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] r, s, rl;
            logic       hr;
            logic [1:0] rsp;
            r   = 4'($urandom);
            s   = 4'($urandom);
            hr  = ($urandom % 4) != 0;
            rsp = (($urandom % 6) == 0) ? 2'b11 : 2'b00;
            rl  = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0000;
            step(r, s, hr, rsp, rl, "R7 R8 R9 R10 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule